// File: doc/BRIEF.md
# Interrupt Trigger Conditioner

This block sits between a set of selected pad signals and an interrupt controller that accepts only active-high levels or rising edges. Each channel resynchronizes its pad signal into the local clock domain, then turns it into a normalized request according to three per-channel control bits: an edge-select bit, an invert bit and a both-edge bit. The invert bit flips the synchronized signal before detection, so level-low and falling-edge triggers reach the controller as an active-high level or a rising pulse. The both-edge bit takes precedence over the other two and fires on any transition.

A global enable gates every output. While it is low, each channel keeps tracking its input history, so turning the enable back on never produces a pulse for a transition that happened while the block was gated. A change of a channel's mode bits is absorbed quietly: the cycle in which the edge-mode setting changes emits no pulse.

Top module: `irq_trig_cond`

## Requirements
- R1: While `rst_n` is low, every `irq_o` bit is 0; all internal history and the stored mode are cleared (the stored mode reads as level-high).
- R2: With `both_i`=0, `edge_i`=0, `inv_i`=0 on a channel, `irq_o` follows the pad level as an active-high level.
- R3: With `both_i`=0, `edge_i`=0, `inv_i`=1, `irq_o` is the inverse of the pad level, so a low pad raises the request.
- R4: With `both_i`=0, `edge_i`=1, `inv_i`=0, each 0-to-1 transition of the synchronized pad gives exactly one cycle of `irq_o`=1; nothing else does.
- R5: With `both_i`=0, `edge_i`=1, `inv_i`=1, each 1-to-0 transition gives exactly one cycle of `irq_o`=1.
- R6: With `both_i`=1, every transition in either direction gives one cycle of `irq_o`=1, whatever `edge_i` and `inv_i` are.
- R7: While `en_i` is low, `irq_o` is 0 on every channel; input history is still tracked, so raising `en_i` gives no pulse for a transition seen while gated.
- R8: In the cycle in which a channel's three mode bits differ from their values of the previous cycle, an edge or both-edge channel emits no pulse; the history is updated in that cycle.
- R9: A pad change is registered by `SYNC_STAGES` flops and then the output flop, so `irq_o` responds at the `SYNC_STAGES+1`-th rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable for all outputs |
| pad_i | input | NCH | Raw selected pad signals, one per channel |
| edge_i | input | NCH | Per channel: 1 = edge trigger, 0 = level trigger |
| inv_i | input | NCH | Per channel: 1 = invert before detection (level-low / falling) |
| both_i | input | NCH | Per channel: 1 = fire on any transition, overrides the others |
| irq_o | output | NCH | Normalized active-high interrupt requests |

## Verification
The bench builds the block with five channels and three synchronizer stages rather than the defaults, so the latency rule is exercised with a depth other than two and every mode can run on its own channel at the same time. Its reference model keeps a history queue of sampled pad vectors and looks back a number of entries derived from the stage count, which reaches the output at exactly the cycle set by R9. Phases with fixed modes, random pad traffic, enable gating across transitions and mode switches on live channels bring the suppression and history rules within reach.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  typedef struct packed {
    logic both;
    logic edge_sel;
    logic inv;
  } trig_mode_t;

  function automatic logic mode_is_edge(trig_mode_t m);
    return m.both | m.edge_sel;
  endfunction
endpackage

// File: rtl/irq_trig_sync.sv
module irq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_trig_chan.sv
module irq_trig_chan
  import irq_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       pad_i,
  input  trig_mode_t mode_i,
  output logic       irq_o
);
  logic       sync_s;
  logic       prev_q, prev_d;
  trig_mode_t mode_q, mode_d;
  logic       irq_q, irq_d;
  logic       hit, cond_now, cond_prev, mode_chg;

  irq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pad_i),
    .q_o  (sync_s)
  );

  always_comb begin
    mode_chg  = (mode_i != mode_q);
    cond_now  = sync_s ^ mode_i.inv;
    cond_prev = prev_q ^ mode_i.inv;
    if (mode_i.both)          hit = sync_s ^ prev_q;
    else if (mode_i.edge_sel) hit = cond_now & ~cond_prev;
    else                      hit = cond_now;
    if (mode_is_edge(mode_i) && mode_chg) hit = 1'b0;
    irq_d  = en_i & hit;
    prev_d = sync_s;
    mode_d = mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      mode_q <= mode_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

  assert_gated_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_o);

  assert_mode_switch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_edge(mode_i) && (mode_i != mode_q)) |=> !irq_o);

  assert_level_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !mode_i.both && !mode_i.edge_sel && !mode_i.inv) |=> (irq_o == $past(sync_s)));

  assert_level_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !mode_i.both && !mode_i.edge_sel && mode_i.inv) |=> (irq_o == !$past(sync_s)));

  assert_any_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i.both && (mode_i == mode_q))
      |=> (irq_o == ($past(sync_s) != $past(sync_s, 2))));
endmodule

// File: rtl/irq_trig_cond.sv
module irq_trig_cond
  import irq_trig_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [NCH-1:0] pad_i,
  input  logic [NCH-1:0] edge_i,
  input  logic [NCH-1:0] inv_i,
  input  logic [NCH-1:0] both_i,
  output logic [NCH-1:0] irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    trig_mode_t mode_c;
    always_comb begin
      mode_c.both     = both_i[c];
      mode_c.edge_sel = edge_i[c];
      mode_c.inv      = inv_i[c];
    end
    irq_trig_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en_i),
      .pad_i (pad_i[c]),
      .mode_i(mode_c),
      .irq_o (irq_o[c])
    );
  end
endmodule

// File: tb/irq_trig_cond_test.sv
module irq_trig_cond_test;
  localparam int N = 5;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic [N-1:0] pad, edg, inv, both, irq;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] hist[$];
  logic [N-1:0] m_edg, m_inv, m_both;
  bit running = 0;

  always #4 clk = ~clk;

  irq_trig_cond #(.NCH(N), .SYNC_STAGES(S)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pad_i(pad),
    .edge_i(edg), .inv_i(inv), .both_i(both), .irq_o(irq)
  );

  task automatic reset_model();
    hist.delete();
    for (int i = 0; i < S + 2; i++) hist.push_front('0);
    m_edg = '0; m_inv = '0; m_both = '0;
  endtask

  // Reference: pad sampled at edge n reaches the output decision S edges later (R9).
  always @(posedge clk) begin
    logic [N-1:0] pad_s, en_s, e_s, i_s, b_s;
    pad_s = pad; e_s = edg; i_s = inv; b_s = both; en_s = {N{en}};
    if (running && rst_n) begin
      logic [N-1:0] exp;
      string req [N];
      hist.push_front(pad_s);
      for (int c = 0; c < N; c++) begin
        logic s, p, hit, chg;
        s = hist[S][c]; p = hist[S+1][c];
        chg = (e_s[c] != m_edg[c]) || (i_s[c] != m_inv[c]) || (b_s[c] != m_both[c]);
        if (b_s[c]) begin hit = s ^ p; req[c] = "R6"; end
        else if (e_s[c]) begin
          hit = (s ^ i_s[c]) & ~(p ^ i_s[c]);
          req[c] = i_s[c] ? "R5" : "R4";
        end else begin
          hit = s ^ i_s[c]; req[c] = i_s[c] ? "R3" : "R2";
        end
        if ((b_s[c] || e_s[c]) && chg) begin hit = 1'b0; req[c] = "R8"; end
        if (!en_s[c]) req[c] = "R7";
        exp[c] = en_s[c] & hit;
      end
      while (hist.size() > S + 2) void'(hist.pop_back());
      m_edg = e_s; m_inv = i_s; m_both = b_s;
      #1;
      for (int c = 0; c < N; c++) begin
        checks++;
        if (irq[c] !== exp[c]) begin
          errors++;
          $display("FAIL %s ch%0d t=%0t irq=%b expected=%b", req[c], c, $time, irq[c], exp[c]);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; pad = '0; edg = '0; inv = '0; both = '0;
    reset_model();
    wait_cyc(3);
    checks++;  // R1: outputs cleared under reset
    if (irq !== '0) begin
      errors++; $display("FAIL R1 irq=%b expected=%b", irq, {N{1'b0}});
    end
    rst_n = 1'b1; running = 1;
    en = 1'b1;
    wait_cyc(6);
    // Fixed modes per channel: R2 level-high, R3 level-low, R4 rise, R5 fall, R6 both
    edg  = 5'b11100;
    inv  = 5'b11010;
    both = 5'b10000;
    wait_cyc(6);
    // Slow square wave on all pads
    for (int k = 0; k < 8; k++) begin pad = ~pad; wait_cyc(7); end
    // Fast toggling and random traffic
    for (int k = 0; k < 12; k++) begin pad = ~pad; wait_cyc(1); end
    for (int k = 0; k < 300; k++) begin pad = N'($urandom); wait_cyc(1 + ($urandom % 3)); end
    // R7: transitions while gated must not reappear after re-enable
    wait_cyc(8);
    en = 1'b0;
    wait_cyc(2);
    pad = ~pad;
    wait_cyc(10);
    en = 1'b1;
    wait_cyc(10);
    for (int k = 0; k < 100; k++) begin
      en = ($urandom % 4) != 0;
      pad = N'($urandom);
      wait_cyc(1 + ($urandom % 4));
    end
    en = 1'b1;
    // R8: mode switches on live channels
    for (int k = 0; k < 200; k++) begin
      if ($urandom % 3 == 0) begin
        edg = N'($urandom); inv = N'($urandom); both = N'($urandom);
      end
      if ($urandom % 2 == 0) pad = N'($urandom);
      wait_cyc(1 + ($urandom % 3));
    end
    // R1 again: reset in mid-traffic
    @(negedge clk);
    running = 0; rst_n = 1'b0;
    #1;
    checks++;
    if (irq !== '0) begin
      errors++; $display("FAIL R1 irq=%b expected=%b", irq, {N{1'b0}});
    end
    pad = '0; edg = '0; inv = '0; both = '0;
    reset_model();
    wait_cyc(2);
    rst_n = 1'b1; running = 1;
    for (int k = 0; k < 4; k++) begin pad = ~pad; wait_cyc(6); end
    wait_cyc(4);
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule